// File: doc/BRIEF.md
# PCI Bridge Host Window Decoder

This block sits behind the host expansion-bus slave of a bus-to-PCI bridge board. It takes the offset of an access relative to the board's base address and sorts it into one of four targets: the large PCI memory aperture, the PCI I/O aperture, PCI configuration space, or the bridge's own control/status word. A configuration access carries three fields to the PCI cycle generator: a target slot, a function number and a register offset. The slot is not a binary field. It is picked by a one-hot group of address bits, so an offset with no bit or several bits set in that group selects nothing.

The control/status word sits inside the configuration window. It holds an interrupt-enable bit and a reset bit that drives the PCI reset line. A read of the word also shows whether a PCI interrupt is pending. The block gates the external PCI interrupt with the enable bit to form the host interrupt request. For a read that reaches no device, the block supplies all ones. It does not generate PCI bus cycles, swap byte lanes or answer board identification.

Top module: `pcibw_window_decoder`

## Requirements
- R1: An offset below 0x1FC00000 asserts `sel_mem` only.
- R2: An offset in 0x1FE00000..0x1FEFFFFF asserts `sel_io` only.
- R3: An offset in 0x1FC00000..0x1FCFFFFF asserts `sel_cfg` when offset bit 15 is 0, and `sel_ctl` when bit 15 is 1. The slot bits do not change this.
- R4: The four selects are never high together. Offsets 0x1FD00000..0x1FDFFFFF, 0x1FF00000..0x1FFFFFFF and 0x20000000 and above assert none of them. A read of such an offset returns 0xFFFFFFFF.
- R5: During a `sel_cfg` access, offset bits 19:16 pick the slot: 0x1 gives slot 0, 0x2 slot 1, 0x4 slot 2 and 0x8 slot 3, each with `slot_hit`=1. Any other pattern gives `slot_hit`=0 and `slot_num`=0.
- R6: During a `sel_cfg` access, `func_num` equals offset bits 10:8 and `reg_off` equals offset bits 7:0. Otherwise both are 0.
- R7: A read with `sel_cfg`=1 and `slot_hit`=0 returns 0xFFFFFFFF. A read of a hit device, of memory or of I/O returns 0, because that data comes from the PCI side. `rdata` is 0 while `rd_en` is low.
- R8: A write with `sel_ctl`=1 loads interrupt-enable from `wdata[30]` and the reset bit from `wdata[31]` at the next rising clock edge. A write to any other offset leaves both bits unchanged.
- R9: A read with `sel_ctl`=1 returns `pci_int` in bit 29, interrupt-enable in bit 30, the reset bit in bit 31 and 0 in bits 28:0.
- R10: `host_irq` is high exactly while `pci_int` and interrupt-enable are both high, in the same cycle.
- R11: A clock edge with `rst_n` low clears interrupt-enable and the reset bit. `pci_rst` always equals the reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 32 | Offset relative to the board base |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| pci_int | input | 1 | External PCI interrupt, active high |
| sel_mem | output | 1 | PCI memory aperture selected |
| sel_io | output | 1 | PCI I/O aperture selected |
| sel_cfg | output | 1 | PCI configuration access |
| sel_ctl | output | 1 | Bridge control/status word selected |
| slot_hit | output | 1 | Configuration access reaches a valid slot |
| slot_num | output | 2 | Target slot number |
| func_num | output | 3 | Target function number |
| reg_off | output | 8 | Configuration register offset |
| rdata | output | 32 | Read data supplied by the bridge |
| pci_rst | output | 1 | PCI reset output |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The selects, the slot, function and register fields, `rdata` and `host_irq` all come from combinational logic. They are due in the same cycle as the offset and strobes. The bench drives inputs at the falling edge and samples them one time unit later, with no clock edge in between. The control bits are due after the first rising edge that follows a write. Each write is therefore held through exactly one rising edge, and its effect is checked at the next falling edge with the strobe already low. In the same way, reset is checked one edge after `rst_n` falls.

// File: rtl/pcibw_pkg.sv
// Package: shared layout of the bridge window decoder.
// Assumes a 32-bit data word. The control word bit positions are fixed here,
// because host software depends on them.
package pcibw_pkg;

    // Region select bundle: at most one member is high.
    typedef struct packed {
        logic mem;
        logic io;
        logic cfg;
        logic ctl;
    } region_t;

    localparam int CTL_RST_BIT = 31;  // PCI reset control
    localparam int CTL_IEN_BIT = 30;  // interrupt enable
    localparam int CTL_IRQ_BIT = 29;  // pending PCI interrupt (read only)

endpackage

// File: rtl/pcibw_region_decode.sv
// Module: pcibw_region_decode
// Sorts a board-relative offset into the memory, I/O, configuration or
// control region. Assumes that the configuration and I/O windows are each
// 2**WIN_BITS bytes and aligned to that size. The memory window runs from
// offset 0 up to MEM_LIMIT (exclusive).
module pcibw_region_decode
    import pcibw_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                WIN_BITS  = 20,
    parameter int                CTL_BIT   = 15,
    parameter logic [ADDR_W-1:0] MEM_LIMIT = 32'h1FC0_0000,
    parameter logic [ADDR_W-1:0] CFG_BASE  = 32'h1FC0_0000,
    parameter logic [ADDR_W-1:0] IO_BASE   = 32'h1FE0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0] tag;
    logic             in_cfg_win;

    assign tag        = addr[ADDR_W-1:WIN_BITS];
    assign in_cfg_win = (tag == CFG_BASE[ADDR_W-1:WIN_BITS]);

    // Classify the offset; the windows do not overlap.
    always_comb begin
        region     = '0;
        region.mem = (addr < MEM_LIMIT);
        region.io  = (tag == IO_BASE[ADDR_W-1:WIN_BITS]);
        region.cfg = in_cfg_win && !addr[CTL_BIT];
        region.ctl = in_cfg_win &&  addr[CTL_BIT];
    end

endmodule

// File: rtl/pcibw_slot_decode.sv
// Module: pcibw_slot_decode
// Turns a one-hot slot group into a binary slot number, and passes the
// function and register fields through. Assumes that `en` is the
// configuration select. Every output is zero while it is low.
module pcibw_slot_decode #(
    parameter int N_SLOTS = 4,
    parameter int FUNC_W  = 3,
    parameter int REG_W   = 8,
    parameter int SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic               en,
    input  logic [N_SLOTS-1:0] slot_bits,
    input  logic [FUNC_W-1:0]  func_bits,
    input  logic [REG_W-1:0]   reg_bits,
    output logic               hit,
    output logic [SLOT_W-1:0]  slot_num,
    output logic [FUNC_W-1:0]  func_num,
    output logic [REG_W-1:0]   reg_off
);
    logic [N_SLOTS-1:0] match;

    // One comparator per slot: the group must be exactly that slot's bit.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        localparam logic [N_SLOTS-1:0] PATTERN = N_SLOTS'(1) << i;
        assign match[i] = en && (slot_bits == PATTERN);
    end

    // Encode the single match into a binary slot number.
    always_comb begin
        slot_num = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (match[i]) slot_num = SLOT_W'(i);
        end
    end

    assign hit      = |match;
    assign func_num = en ? func_bits : '0;
    assign reg_off  = en ? reg_bits  : '0;

endmodule

// File: rtl/pcibw_ctrl_reg.sv
// Module: pcibw_ctrl_reg
// Holds the bridge control bits (interrupt enable, PCI reset), builds the
// status word and gates the host interrupt. Assumes that `wr` is already
// qualified by the control select. Reset is synchronous and active low.
module pcibw_ctrl_reg
    import pcibw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_rst,
    input  logic              wr_ien,
    input  logic              pci_int,
    output logic              ien,
    output logic              pci_rst,
    output logic              host_irq,
    output logic [DATA_W-1:0] status
);
    // Control bits: cleared by reset, loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 1'b0;
            pci_rst <= 1'b0;
        end else if (wr) begin
            ien     <= wr_ien;
            pci_rst <= wr_rst;
        end
    end

    // Status word seen by a control read.
    always_comb begin
        status              = '0;
        status[CTL_RST_BIT] = pci_rst;
        status[CTL_IEN_BIT] = ien;
        status[CTL_IRQ_BIT] = pci_int;
    end

    // Host request: interrupt gated by the enable.
    assign host_irq = pci_int && ien;

    // R8: a control write loads both bits
    assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (pci_rst == $past(wr_rst)) && (ien == $past(wr_ien)));

    // R8: with no control write the bits hold
    assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(pci_rst) && $stable(ien));

endmodule

// File: rtl/pcibw_window_decoder.sv
// Module: pcibw_window_decoder (top)
// Decodes the bridge's host window, holds the control word and supplies
// bridge-side read data. Assumes that read and write strobes qualify the
// offset and data in the same cycle. Decode is combinational; only the
// control bits are registered.
module pcibw_window_decoder
    import pcibw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int N_SLOTS  = 4,
    parameter int SLOT_LSB = 16,
    parameter int FUNC_LSB = 8,
    parameter int FUNC_W   = 3,
    parameter int REG_W    = 8,
    parameter int SLOT_W   = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pci_int,
    output logic              sel_mem,
    output logic              sel_io,
    output logic              sel_cfg,
    output logic              sel_ctl,
    output logic              slot_hit,
    output logic [SLOT_W-1:0] slot_num,
    output logic [FUNC_W-1:0] func_num,
    output logic [REG_W-1:0]  reg_off,
    output logic [DATA_W-1:0] rdata,
    output logic              pci_rst,
    output logic              host_irq
);
    region_t           region;
    logic              ien;
    logic [DATA_W-1:0] status;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[CTL_IRQ_BIT:0];

    pcibw_region_decode #(
        .ADDR_W (ADDR_W)
    ) u_region (
        .addr   (addr),
        .region (region)
    );

    assign sel_mem = region.mem;
    assign sel_io  = region.io;
    assign sel_cfg = region.cfg;
    assign sel_ctl = region.ctl;

    pcibw_slot_decode #(
        .N_SLOTS (N_SLOTS),
        .FUNC_W  (FUNC_W),
        .REG_W   (REG_W),
        .SLOT_W  (SLOT_W)
    ) u_slot (
        .en        (region.cfg),
        .slot_bits (addr[SLOT_LSB +: N_SLOTS]),
        .func_bits (addr[FUNC_LSB +: FUNC_W]),
        .reg_bits  (addr[0 +: REG_W]),
        .hit       (slot_hit),
        .slot_num  (slot_num),
        .func_num  (func_num),
        .reg_off   (reg_off)
    );

    pcibw_ctrl_reg #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en && region.ctl),
        .wr_rst   (wdata[CTL_RST_BIT]),
        .wr_ien   (wdata[CTL_IEN_BIT]),
        .pci_int  (pci_int),
        .ien      (ien),
        .pci_rst  (pci_rst),
        .host_irq (host_irq),
        .status   (status)
    );

    // Bridge read data: status word, all ones on a miss, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (region.ctl)
                rdata = status;
            else if (!region.mem && !region.io && !(region.cfg && slot_hit))
                rdata = '1;
        end
    end

    // R4: selects are mutually exclusive
    assert_sel_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_mem, sel_io, sel_cfg, sel_ctl}));

    // R5: a slot hit only occurs on a configuration access
    assert_hit_in_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_hit |-> sel_cfg);

    // R9: unused status bits read as zero
    assert_ctl_zero_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_ctl) |-> (rdata[CTL_IRQ_BIT-1:0] == '0));

    // R10: host request needs a PCI interrupt
    assert_irq_needs_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> pci_int);

    // R11: the PCI reset output follows the control bit status
    assert_rst_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_ctl) |-> (rdata[CTL_RST_BIT] == pci_rst));

endmodule

// File: tb/sim_pcibw_window_decoder.sv
module sim_pcibw_window_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    // Table: offset, selects {mem,io,cfg,ctl}, hit, slot, func, reg, rdata (read)
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0000_0000, 32'h1FBF_FFFC, 32'h1FC0_0000, 32'h1FC1_0304,
        32'h1FC2_0510, 32'h1FC4_07FC, 32'h1FC8_0100, 32'h1FC3_0000,
        32'h1FCF_0000, 32'h1FC0_8000, 32'h1FE0_0000, 32'h1FEF_FFFC,
        32'h1FD0_0000, 32'h1FF0_0000, 32'h2000_0000, 32'h1FC1_8000};
    localparam logic [3:0] V_SEL [NV] = '{
        4'b1000, 4'b1000, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010, 4'b0010,
        4'b0010, 4'b0001, 4'b0100, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0001};
    localparam logic V_HIT [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0] V_SLOT [NV] = '{
        2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0,
        2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    localparam logic [2:0] V_FUNC [NV] = '{
        3'd0, 3'd0, 3'd0, 3'd3, 3'd5, 3'd7, 3'd1, 3'd0,
        3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};
    localparam logic [7:0] V_REG [NV] = '{
        8'h00, 8'h00, 8'h00, 8'h04, 8'h10, 8'hFC, 8'h00, 8'h00,
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    localparam logic [31:0] V_RD [NV] = '{
        32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h0};

    localparam logic [31:0] CTL_ADDR = 32'h1FC0_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        pci_int = 1'b0;
    logic        sel_mem, sel_io, sel_cfg, sel_ctl, slot_hit;
    logic [1:0]  slot_num;
    logic [2:0]  func_num;
    logic [7:0]  reg_off;
    logic [31:0] rdata;
    logic        pci_rst, host_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcibw_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .pci_int(pci_int), .sel_mem(sel_mem), .sel_io(sel_io),
        .sel_cfg(sel_cfg), .sel_ctl(sel_ctl), .slot_hit(slot_hit),
        .slot_num(slot_num), .func_num(func_num), .reg_off(reg_off),
        .rdata(rdata), .pci_rst(pci_rst), .host_irq(host_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One control write, held through exactly one rising edge.
    task automatic ctl_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctl_read(input string req, input logic [31:0] exp);
        @(negedge clk);
        addr = CTL_ADDR; rd_en = 1'b1;
        #1 chk(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        chk("R11 reset pci_rst", {31'b0, pci_rst}, 32'h0);
        chk("R11 reset host_irq", {31'b0, host_irq}, 32'h0);
        rst_n = 1'b1;

        // R1..R7: decode table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr = V_ADDR[i]; rd_en = 1'b1;
            #1;
            chk($sformatf("R1/R2/R3/R4 selects #%0d", i),
                {28'b0, sel_mem, sel_io, sel_cfg, sel_ctl}, {28'b0, V_SEL[i]});
            chk($sformatf("R5 hit #%0d", i), {31'b0, slot_hit}, {31'b0, V_HIT[i]});
            chk($sformatf("R5 slot #%0d", i), {30'b0, slot_num}, {30'b0, V_SLOT[i]});
            chk($sformatf("R6 fields #%0d", i), {21'b0, func_num, reg_off},
                {21'b0, V_FUNC[i], V_REG[i]});
            chk($sformatf("R7/R4 rdata #%0d", i), rdata, V_RD[i]);
        end
        rd_en = 1'b0;
        #1 chk("R7 rdata idle", rdata, 32'h0);

        // R8/R9/R11: control write sets both bits
        ctl_write(CTL_ADDR, 32'hC000_0000);
        #1 chk("R11 pci_rst follows", {31'b0, pci_rst}, 32'h1);
        ctl_read("R9 read C0", 32'hC000_0000);

        // R10: interrupt gating
        pci_int = 1'b1;
        #1 chk("R10 irq on", {31'b0, host_irq}, 32'h1);
        ctl_read("R9 read with int", 32'hE000_0000);

        // R8: writes elsewhere ignored
        ctl_write(32'h1FC1_0000, 32'h0000_0000);
        ctl_write(32'h0000_0000, 32'h0000_0000);
        ctl_write(32'h1FD0_0000, 32'h0000_0000);
        #1 chk("R8 ignore pci_rst", {31'b0, pci_rst}, 32'h1);
        ctl_read("R8 ignore status", 32'hE000_0000);

        // R8: write only enable
        ctl_write(CTL_ADDR, 32'h4000_0000);
        #1 chk("R8 rst cleared", {31'b0, pci_rst}, 32'h0);
        chk("R10 irq still on", {31'b0, host_irq}, 32'h1);
        ctl_read("R9 read 60", 32'h6000_0000);

        // R10: enable off blocks request
        ctl_write(CTL_ADDR, 32'h8000_0000);
        #1 chk("R10 irq gated", {31'b0, host_irq}, 32'h0);
        chk("R11 pci_rst set", {31'b0, pci_rst}, 32'h1);
        ctl_read("R9 read A0", 32'hA000_0000);
        pci_int = 1'b0;
        ctl_read("R9 read 80", 32'h8000_0000);

        // R11: reset clears the bits
        ctl_write(CTL_ADDR, 32'hC000_0000);
        pci_int = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R11 reset clears rst", {31'b0, pci_rst}, 32'h0);
        chk("R11 reset clears ien", {31'b0, host_irq}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule